// File: doc/BRIEF.md
# Word-Wide Arithmetic Logic Unit with Signed Compare

This block is a purely combinational arithmetic logic unit for a 32-bit datapath. It is built as a chain of identical one-bit slices joined by a rippling carry. The top slice has extra logic for overflow detection and for the signed compare. The block takes two operands, a carry-in and a 3-bit control word. It returns a result word, a zero flag, a signed overflow flag and the carry out of the top bit.

The control word is `{invert_b, op[1:0]}`. `invert_b` feeds the complement of B to every slice, and it also forces the carry into bit 0 high. Subtraction therefore reuses the adder. The op field picks, in every slice, among four values: the logic AND, the logic OR, the adder sum, or a "less" input.

Only slice 0 receives a live "less" input. That input is the true sign of A minus B, taken from the top slice. Equality is tested by subtracting and reading the zero flag. There are no clocks and no state, and outputs settle one propagation delay after the inputs.

Top module: `alu_word`

## Requirements
- R1: Control 3'b000 gives result = A AND B.
- R2: Control 3'b001 gives result = A OR B.
- R3: Control 3'b010 gives result = A + B + carry-in, truncated to 32 bits.
- R4: Control 3'b110 gives result = A - B; the carry into bit 0 is 1 whatever the carry-in pin holds.
- R5: Control 3'b111 gives 1 in bit 0 when A < B as signed two's complement values, and 0 otherwise. Bits 31..1 are 0. The answer stays correct when A - B overflows.
- R6: The zero flag is 1 exactly when all 32 result bits are 0, for every control value.
- R7: For every control value, the overflow flag is 1 exactly when the adder's two inputs (A and B or ~B) share a sign and the adder sum's sign differs from it.
- R8: For every control value, carry-out equals bit 32 of A + B' + c0. Here B' is B or ~B as chosen by bit 2, and c0 is carry-in OR bit 2.
- R9: With bit 2 set, the logic codes act on ~B: 3'b100 gives A AND NOT B, and 3'b101 gives A OR NOT B.
- R10: Control 3'b011 puts the true sign of A + B + carry-in (the sum sign XOR overflow) in bit 0, with bits 31..1 at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| ctrl_i | input | 3 | Control: bit 2 inverts B and forces carry into bit 0; bits 1:0 pick AND, OR, sum, less |
| cin_i | input | 1 | Carry into bit 0, used when bit 2 of control is 0 |
| result_o | output | 32 | Selected result word |
| zero_o | output | 1 | High when result is all zeros |
| ovf_o | output | 1 | Signed overflow of the adder |
| cout_o | output | 1 | Carry out of the most significant slice |

## Verification
A broken carry link between slices appears at once in the sum. It surfaces as a wrong result bit or a wrong carry-out for operands whose carries cross that link. Corner cases such as all-ones plus one drive a carry through every slice.

A fault in the top slice's overflow or sign logic shows as a wrong compare in bit 0 only when A - B overflows. For that reason the bench applies the extreme values 0x7FFFFFFF and 0x80000000 against each other. A stuck zero detector is caught by any vector whose result is nonzero, and also by equal operands subtracted.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CTRL_W = 3;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } alu_sel_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic     a_i,
  input  logic     b_i,
  input  logic     invert_b_i,
  input  logic     carry_i,
  input  logic     less_i,
  input  alu_sel_e sel_i,
  output logic     res_o,
  output logic     carry_o
);
  logic b_eff;
  logic sum;

  assign b_eff   = b_i ^ invert_b_i;
  assign sum     = a_i ^ b_eff ^ carry_i;
  assign carry_o = (a_i & b_eff) | (carry_i & (a_i ^ b_eff));

  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_i & b_eff;
      SEL_OR:   res_o = a_i | b_eff;
      SEL_SUM:  res_o = sum;
      default:  res_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import alu_pkg::*;
(
  input  logic     a_i,
  input  logic     b_i,
  input  logic     invert_b_i,
  input  logic     carry_i,
  input  alu_sel_e sel_i,
  output logic     res_o,
  output logic     carry_o,
  output logic     ovf_o,
  output logic     true_sign_o
);
  logic sum_sign;

  alu_slice u_core (
    .a_i        (a_i),
    .b_i        (b_i),
    .invert_b_i (invert_b_i),
    .carry_i    (carry_i),
    .less_i     (1'b0),
    .sel_i      (sel_i),
    .res_o      (res_o),
    .carry_o    (carry_o)
  );

  // Sign of the adder output, recomputed locally for the compare path.
  assign sum_sign    = a_i ^ b_i ^ invert_b_i ^ carry_i;
  assign ovf_o       = carry_i ^ carry_o;
  assign true_sign_o = sum_sign ^ ovf_o;
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] word_i,
  output logic             zero_o
);
  assign zero_o = ~|word_i;
endmodule

// File: rtl/alu_word.sv
module alu_word
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              cin_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              zero_o,
  output logic              ovf_o,
  output logic              cout_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic     invert_b;
  alu_sel_e sel;
  logic     carry [0:WIDTH];
  logic     true_sign;

  assign invert_b = ctrl_i[2];
  assign sel      = alu_sel_e'(ctrl_i[1:0]);
  assign carry[0] = cin_i | invert_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == MSB) begin : g_top
      alu_msb_slice u_msb (
        .a_i         (a_i[i]),
        .b_i         (b_i[i]),
        .invert_b_i  (invert_b),
        .carry_i     (carry[i]),
        .sel_i       (sel),
        .res_o       (result_o[i]),
        .carry_o     (carry[i+1]),
        .ovf_o       (ovf_o),
        .true_sign_o (true_sign)
      );
    end else if (i == 0) begin : g_low
      alu_slice u_bit (
        .a_i        (a_i[i]),
        .b_i        (b_i[i]),
        .invert_b_i (invert_b),
        .carry_i    (carry[i]),
        .less_i     (true_sign),
        .sel_i      (sel),
        .res_o      (result_o[i]),
        .carry_o    (carry[i+1])
      );
    end else begin : g_mid
      alu_slice u_bit (
        .a_i        (a_i[i]),
        .b_i        (b_i[i]),
        .invert_b_i (invert_b),
        .carry_i    (carry[i]),
        .less_i     (1'b0),
        .sel_i      (sel),
        .res_o      (result_o[i]),
        .carry_o    (carry[i+1])
      );
    end
  end

  assign cout_o = carry[WIDTH];

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .word_i (result_o),
    .zero_o (zero_o)
  );
endmodule

// File: rtl/alu_word_chk.sv
module alu_word_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       ctrl_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o,
  input logic             cout_o
);
  logic [WIDTH:0] wide_sum;
  assign wide_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    if (ctrl_i == 3'b000) a_r1_and: assert (result_o == (a_i & b_i));
    if (ctrl_i == 3'b110) a_r4_sub: assert (result_o == (a_i - b_i));
    if (ctrl_i == 3'b111) a_r5_slt_upper: assert (result_o[WIDTH-1:1] == '0);
    if (ctrl_i == 3'b111) a_r5_slt_bit: assert (result_o[0] == ($signed(a_i) < $signed(b_i)));
    a_r6_zero: assert (zero_o == (result_o == '0));
    if (ctrl_i == 3'b010)
      a_r7_add_ovf: assert (ovf_o == ((a_i[WIDTH-1] == b_i[WIDTH-1]) && (result_o[WIDTH-1] != a_i[WIDTH-1])));
    if (ctrl_i == 3'b010) a_r8_add_carry: assert ({cout_o, result_o} == wide_sum);
  end
endmodule

bind alu_word alu_word_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .ctrl_i   (ctrl_i),
  .cin_i    (cin_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o),
  .cout_o   (cout_o)
);

// File: tb/tb_alu_word.sv
module tb_alu_word;
  localparam int W = 32;
  localparam int WATCHDOG_CYCLES = 200000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a, b;
  logic [2:0]   ctrl;
  logic         cin;
  logic [W-1:0] result;
  logic         zero, ovf, cout;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] res;
    logic         z;
    logic         v;
    logic         c;
    string        tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  alu_word dut (
    .a_i(a), .b_i(b), .ctrl_i(ctrl), .cin_i(cin),
    .result_o(result), .zero_o(zero), .ovf_o(ovf), .cout_o(cout)
  );

  // Reference model written from the requirement list.
  function automatic exp_t model(logic [W-1:0] x, logic [W-1:0] y,
                                 logic [2:0] k, logic ci, string tag);
    exp_t e;
    logic [W-1:0] yb;
    logic         c0;
    logic [W:0]   s;
    logic         v;
    yb = k[2] ? ~y : y;
    c0 = ci | k[2];
    s  = {1'b0, x} + {1'b0, yb} + {{W{1'b0}}, c0};
    v  = (x[W-1] == yb[W-1]) && (s[W-1] != x[W-1]);
    case (k[1:0])
      2'd0: e.res = x & yb;
      2'd1: e.res = x | yb;
      2'd2: e.res = s[W-1:0];
      default: e.res = {{(W-1){1'b0}}, s[W-1] ^ v};
    endcase
    if (k == 3'b111) e.res = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
    e.z = (e.res == '0);
    e.v = v;
    e.c = s[W];
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] k,
                       logic ci, string tag);
    @(posedge clk);
    a = x; b = y; ctrl = k; cin = ci;
    sb.push_back(model(x, y, k, ci, tag));
  endtask

  // Monitor: sample mid-cycle, after inputs driven at the rising edge settle.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        applied++;
        if (result !== e.res || zero !== e.z || ovf !== e.v || cout !== e.c) begin
          miscompares++;
          $display("FAIL %s: actual res=%h z=%b v=%b c=%b expected res=%h z=%b v=%b c=%b (a=%h b=%h ctrl=%b cin=%b)",
                   e.tag, result, zero, ovf, cout, e.res, e.z, e.v, e.c, a, b, ctrl, cin);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; ctrl = 3'b000; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset-state vector: all zero inputs give zero result, zero flag high (R6).
    drive('0, '0, 3'b000, 1'b0, "R6 idle");

    // Corners
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b010, 1'b0, "R3 R8 full carry");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 3'b010, 1'b0, "R7 add overflow");
    drive(32'h8000_0000, 32'h8000_0000, 3'b010, 1'b0, "R7 R8 neg overflow");
    drive(32'h1234_5678, 32'h1234_5678, 3'b110, 1'b0, "R4 R6 equal sub");
    drive(32'h0000_0005, 32'h0000_0003, 3'b110, 1'b0, "R4 cin ignored low");
    drive(32'h0000_0005, 32'h0000_0003, 3'b110, 1'b1, "R4 cin ignored high");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 3'b111, 1'b0, "R5 max vs min");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 3'b111, 1'b0, "R5 min vs max");
    drive(32'hFFFF_FFFF, 32'h0000_0000, 3'b111, 1'b0, "R5 minus one");
    drive(32'h0000_0004, 32'h0000_0004, 3'b111, 1'b0, "R5 equal");
    drive(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'b000, 1'b0, "R1 pattern");
    drive(32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'b000, 1'b0, "R1 R6 disjoint");
    drive(32'hF0F0_0000, 32'h0000_000F, 3'b001, 1'b0, "R2 pattern");
    drive(32'hFFFF_0000, 32'hFF00_FF00, 3'b100, 1'b0, "R9 and-not");
    drive(32'h0000_0000, 32'hFFFF_FFFF, 3'b101, 1'b0, "R9 R6 or-not zero");
    drive(32'h7FFF_FFFF, 32'h0000_0000, 3'b011, 1'b1, "R10 overflow sign");
    drive(32'h0000_0001, 32'hFFFF_FFFD, 3'b011, 1'b0, "R10 negative sum");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] k;
      string t;
      k = 3'($urandom_range(0, 7));
      case (k)
        3'b000: t = "R1 R7 R8 rand";
        3'b001: t = "R2 R7 R8 rand";
        3'b010: t = "R3 R7 R8 rand";
        3'b110: t = "R4 R7 R8 rand";
        3'b111: t = "R5 R6 rand";
        3'b011: t = "R10 rand";
        default: t = "R9 rand";
      endcase
      drive($urandom(), (i % 8 == 0) ? 32'($urandom_range(0, 3)) : $urandom(),
            k, 1'($urandom_range(0, 1)), t);
    end

    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule